// File: doc/BRIEF.md
# Dual Maskable Time Alarm Unit

This block watches the current calendar time, held as BCD fields, and tests it against two programmable alarm settings once per second. The first alarm holds seconds, minutes, hours and a day-or-date byte; the second holds minutes, hours and a day-or-date byte, and it can only fire at second zero. Each alarm byte has a mask bit that removes its field from the comparison. This gives repeat rates from once per second (or once per minute for the second alarm) up to a full day-plus-time match.

A match sets a sticky flag for that alarm. The flag stays set until software clears it. A single active-low output pin carries one of two signals, chosen by a control bit. In interrupt mode it is a level interrupt, driven by the enabled flags. In square-wave mode it passes through the half-second phase of the time base as a 1 Hz, 50% duty wave. The time counter and the serial bus sit outside this block. Software reaches the alarm bytes, the control bits and the flags through a simple write-strobe register port with combinational read data.

Top module: `alarm_unit`

## Requirements
- R1: Register map. Addresses 0..3 hold the first alarm's seconds, minutes, hours and day/date bytes. Addresses 5..7 hold the second alarm's minutes, hours and day/date bytes. Address 4 reads 0 and ignores writes. Address 8 is control: bit 0 enables alarm 1, bit 1 enables alarm 2, and bit 2 selects interrupt mode (1) or square-wave mode (0). Address 9 is status: bit 0 is the alarm 1 flag and bit 1 is the alarm 2 flag. All other bits read as 0.
- R2: Bit 7 of an alarm byte is a mask. A masked field always counts as matching, so the first alarm with all four masks set fires on every second tick.
- R3: An unmasked seconds, minutes or hours field matches only when its bits 6..0 equal bits 6..0 of the current field. Hours therefore includes its 12/24 and AM/PM bits in the comparison.
- R4: In an unmasked day/date byte, bit 6 = 0 compares bits 5..0 with the date of the month, and bit 6 = 1 compares them with the day of the week.
- R5: The second alarm requires the current seconds to be 00 in addition to its unmasked fields. With all its masks set, it fires once per minute.
- R6: Matches take effect only on a cycle where `sec_tick` is high. A flag never rises without a tick in the cycle before.
- R7: A match sets its flag one clock after the tick, whatever the enable and mode bits are. The flag then stays set.
- R8: A write to status clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A match in the same cycle as a clearing write wins, and the flag ends up set.
- R9: In interrupt mode, `int_n` is low exactly while (flag1 AND enable1) OR (flag2 AND enable2). It stays low until software clears the causing flag or its enable.
- R10: In square-wave mode, `int_n` follows `half_phase`, regardless of the flags.
- R11: After reset, all alarm bytes are 0x00, control reads 0x04 (interrupt mode, both enables off), status reads 0x00, and `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe of the once-per-second time update |
| half_phase | input | 1 | Half-second phase of the time base (1 Hz, 50% duty) |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours byte with mode bits, BCD |
| cur_wday | input | 8 | Current day of week |
| cur_mday | input | 8 | Current date of month, BCD |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| int_n | output | 1 | Active-low interrupt or 1 Hz square wave |

## Verification
A register write, or a tick with the time fields, is driven before one rising edge. The flag it causes can be read back at the falling edge after that rise, so its latency is one clock. `int_n` and `reg_rdata` are combinational from the registered state and from `half_phase`. They are therefore sampled a step after the address or phase changes, with no further edge. The bench drives every input on the falling edge and samples only at later falling edges, so each result is read in the first half-cycle after the edge it depends on.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NUM_ALARMS      = 2;
    localparam int DATA_W          = 8;
    localparam int ADDR_W          = 4;
    localparam int BYTES_PER_ALARM = 4;
    localparam int FIELD_SEC       = 0;
    localparam int FIELD_MIN       = 1;
    localparam int FIELD_HOUR      = 2;
    localparam int FIELD_DD        = 3;
    localparam int CTRL_ADDR       = NUM_ALARMS * BYTES_PER_ALARM;
    localparam int STAT_ADDR       = CTRL_ADDR + 1;
    localparam int MASK_BIT        = 7;
    localparam int DAYSEL_BIT      = 6;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] wday;
        logic [DATA_W-1:0] mday;
    } cal_time_t;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] dd;
    } alarm_cfg_t;

    typedef enum logic {
        PIN_SQUARE = 1'b0,
        PIN_IRQ    = 1'b1
    } pin_mode_e;

    function automatic logic alarm_has_sec(input int idx);
        return idx == 0;
    endfunction

    function automatic logic field_hit(input logic [DATA_W-1:0] cfg,
                                       input logic [DATA_W-1:0] now);
        return cfg[MASK_BIT] | (cfg[6:0] == now[6:0]);
    endfunction

    function automatic logic dd_hit(input logic [DATA_W-1:0] cfg,
                                    input logic [DATA_W-1:0] wday,
                                    input logic [DATA_W-1:0] mday);
        logic same;
        same = cfg[DAYSEL_BIT] ? (cfg[5:0] == wday[5:0])
                               : (cfg[5:0] == mday[5:0]);
        return cfg[MASK_BIT] | same;
    endfunction

endpackage

// File: rtl/alm_match.sv
module alm_match
    import alarm_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1
) (
    input  alarm_cfg_t cfg_i,
    input  cal_time_t  now_i,
    output logic       hit_o
);

    logic sec_ok;
    logic min_ok;
    logic hour_ok;
    logic dd_ok;

    generate
        if (HAS_SEC) begin : g_sec_field
            assign sec_ok = field_hit(cfg_i.sec, now_i.sec);
        end else begin : g_sec_zero
            assign sec_ok = (now_i.sec == '0);
        end
    endgenerate

    assign min_ok  = field_hit(cfg_i.min, now_i.min);
    assign hour_ok = field_hit(cfg_i.hour, now_i.hour);
    assign dd_ok   = dd_hit(cfg_i.dd, now_i.wday, now_i.mday);
    assign hit_o   = sec_ok & min_ok & hour_ok & dd_ok;

endmodule

// File: rtl/alm_regs.sv
module alm_regs
    import alarm_pkg::*;
#(
    parameter int N  = NUM_ALARMS,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    input  logic                  tick_i,
    input  logic [N-1:0]          hit_i,
    output alarm_cfg_t [N-1:0]    cfg_o,
    output logic [N-1:0]          en_o,
    output pin_mode_e             mode_o,
    output logic [N-1:0]          flag_o
);

    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

    logic [N-1:0][BYTES_PER_ALARM-1:0][DATA_W-1:0] bytes_q;
    logic [N-1:0]                                  en_q;
    pin_mode_e                                     mode_q;
    logic [N-1:0]                                  flag_q;
    logic                                          stat_wr;
    logic                                          ctrl_wr;

    assign stat_wr = we_i && (addr_i == STAT_A);
    assign ctrl_wr = we_i && (addr_i == CTRL_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            en_q    <= '0;
            mode_q  <= PIN_IRQ;
            flag_q  <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int k = 0; k < BYTES_PER_ALARM; k++) begin
                    if (we_i && (addr_i == AW'(i * BYTES_PER_ALARM + k))
                        && (k != FIELD_SEC || alarm_has_sec(i))) begin
                        bytes_q[i][k] <= wdata_i;
                    end
                end
                flag_q[i] <= (stat_wr ? (flag_q[i] & wdata_i[i]) : flag_q[i])
                             | (tick_i & hit_i[i]);
            end
            if (ctrl_wr) begin
                en_q   <= wdata_i[N-1:0];
                mode_q <= pin_mode_e'(wdata_i[N]);
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < BYTES_PER_ALARM; k++) begin
                if ((addr_i == AW'(i * BYTES_PER_ALARM + k))
                    && (k != FIELD_SEC || alarm_has_sec(i))) begin
                    rdata_o = bytes_q[i][k];
                end
            end
        end
        if (addr_i == CTRL_A) begin
            rdata_o[N:0] = {mode_q, en_q};
        end
        if (addr_i == STAT_A) begin
            rdata_o[N-1:0] = flag_q;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cfg
            assign cfg_o[g] = '{sec:  bytes_q[g][FIELD_SEC],
                                min:  bytes_q[g][FIELD_MIN],
                                hour: bytes_q[g][FIELD_HOUR],
                                dd:   bytes_q[g][FIELD_DD]};

            // R6: a flag can only rise after a tick cycle
            a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
                !tick_i |=> !$rose(flag_q[g]));

            // R7: a tick with a match leaves the flag set
            a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
                (tick_i && hit_i[g]) |=> flag_q[g]);

            // R8: writing one keeps a set flag
            a_r8_one_keeps: assert property (@(posedge clk) disable iff (rst)
                (stat_wr && wdata_i[g] && flag_q[g]) |=> flag_q[g]);

            // R8: writing zero clears unless a match arrives together
            a_r8_zero_clears: assert property (@(posedge clk) disable iff (rst)
                (stat_wr && !wdata_i[g] && !(tick_i && hit_i[g])) |=> !flag_q[g]);
        end
    endgenerate

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/alm_pin.sv
module alm_pin
    import alarm_pkg::*;
#(
    parameter int N = NUM_ALARMS
) (
    input  pin_mode_e    mode_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] flag_i,
    input  logic         phase_i,
    output logic         pin_n_o
);

    logic irq_active;

    assign irq_active = |(en_i & flag_i);

    always_comb begin
        unique case (mode_i)
            PIN_IRQ:    pin_n_o = ~irq_active;
            PIN_SQUARE: pin_n_o = phase_i;
            default:    pin_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sec_tick,
    input  logic        half_phase,
    input  logic [7:0]  cur_sec,
    input  logic [7:0]  cur_min,
    input  logic [7:0]  cur_hour,
    input  logic [7:0]  cur_wday,
    input  logic [7:0]  cur_mday,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        int_n
);

    cal_time_t                     now;
    alarm_cfg_t [NUM_ALARMS-1:0]   cfg;
    logic       [NUM_ALARMS-1:0]   hit;
    logic       [NUM_ALARMS-1:0]   en;
    logic       [NUM_ALARMS-1:0]   flag;
    pin_mode_e                     mode;

    assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour,
                   wday: cur_wday, mday: cur_mday};

    alm_regs #(
        .N  (NUM_ALARMS),
        .AW (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .tick_i  (sec_tick),
        .hit_i   (hit),
        .cfg_o   (cfg),
        .en_o    (en),
        .mode_o  (mode),
        .flag_o  (flag)
    );

    generate
        for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_match
            alm_match #(
                .HAS_SEC (alarm_has_sec(g))
            ) u_match (
                .cfg_i (cfg[g]),
                .now_i (now),
                .hit_o (hit[g])
            );
            if (!alarm_has_sec(g)) begin : g_zero_chk
                // R5: a seconds-less alarm only rises after a tick at second 00
                a_r5_rise_at_zero_sec: assert property (@(posedge clk) disable iff (rst)
                    $rose(flag[g]) |-> ($past(cur_sec) == 8'h00));
            end
        end
    endgenerate

    alm_pin #(
        .N (NUM_ALARMS)
    ) u_pin (
        .mode_i  (mode),
        .en_i    (en),
        .flag_i  (flag),
        .phase_i (half_phase),
        .pin_n_o (int_n)
    );

    // R9: an asserted interrupt holds until control or status is written
    a_r9_level_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == PIN_IRQ && !int_n &&
         !(reg_we && (reg_addr == 4'(CTRL_ADDR) || reg_addr == 4'(STAT_ADDR))))
        |=> !int_n);

    // R11: interrupt pin released in the cycle after reset
    a_r11_pin_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> int_n);

endmodule

// File: tb/alarm_unit_bench.sv
module alarm_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [7:0] a1s, a1m, a1h, a1d;
        logic [7:0] a2m, a2h, a2d;
        logic [7:0] ts, tm, th, tw, td;
        logic [1:0] exp_flags;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R2: all masks, non-zero seconds -> only alarm 1
        '{8'h80,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h17,8'h05,8'h10,8'h03,8'h12, 2'b01},
        // R5: all masks, seconds 00 -> both
        '{8'h80,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h00,8'h05,8'h10,8'h03,8'h12, 2'b11},
        // R3: seconds-only match hits
        '{8'h30,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h30,8'h41,8'h09,8'h01,8'h02, 2'b01},
        // R3: seconds-only miss
        '{8'h30,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h31,8'h41,8'h09,8'h01,8'h02, 2'b00},
        // R3: h:m:s hit, alarm 2 blocked by nonzero seconds (R5)
        '{8'h45,8'h22,8'h11,8'h80, 8'h22,8'h11,8'h80, 8'h45,8'h22,8'h11,8'h06,8'h28, 2'b01},
        // R5: same time at second 00 -> only alarm 2
        '{8'h45,8'h22,8'h11,8'h80, 8'h22,8'h11,8'h80, 8'h00,8'h22,8'h11,8'h06,8'h28, 2'b10},
        // R4: day select on 1, date select on 2
        '{8'h00,8'h00,8'h00,8'h45, 8'h00,8'h00,8'h15, 8'h00,8'h00,8'h00,8'h05,8'h15, 2'b11},
        // R4: weekday differs -> alarm 1 misses
        '{8'h00,8'h00,8'h00,8'h45, 8'h00,8'h00,8'h15, 8'h00,8'h00,8'h00,8'h04,8'h15, 2'b10},
        // R4: date select misses, day select hits
        '{8'h00,8'h00,8'h00,8'h05, 8'h00,8'h00,8'h44, 8'h00,8'h00,8'h00,8'h04,8'h15, 2'b10},
        // R3: hour mode bit differs -> miss
        '{8'h80,8'h80,8'h52,8'h80, 8'h80,8'h80,8'h80, 8'h00,8'h00,8'h12,8'h01,8'h01, 2'b10}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       half_phase = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_wday = '0, cur_mday = '0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alarm_unit u_alarm_unit (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .half_phase(half_phase),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_n(int_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, dd);
        cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; cur_mday = dd;
    endtask

    task automatic tick_once();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        rd(4'd8, d); check("R11 control reset", d, 8'h04);
        rd(4'd9, d); check("R11 status reset", d, 8'h00);
        rd(4'd2, d); check("R11 alarm byte reset", d, 8'h00);
        check("R11 pin idle", {7'b0, int_n}, 8'h01);

        // R1: readback layout
        wr(4'd2, 8'hD2); rd(4'd2, d); check("R1 alarm1 hour readback", d, 8'hD2);
        wr(4'd4, 8'h5A); rd(4'd4, d); check("R1 reserved slot", d, 8'h00);
        wr(4'd8, 8'hF8); rd(4'd8, d); check("R1 control bits", d, 8'h00);
        wr(4'd8, 8'h04);

        // Table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            wr(4'd0, VECS[v].a1s); wr(4'd1, VECS[v].a1m);
            wr(4'd2, VECS[v].a1h); wr(4'd3, VECS[v].a1d);
            wr(4'd5, VECS[v].a2m); wr(4'd6, VECS[v].a2h);
            wr(4'd7, VECS[v].a2d);
            wr(4'd9, 8'h00);
            set_time(VECS[v].ts, VECS[v].tm, VECS[v].th, VECS[v].tw, VECS[v].td);
            tick_once();
            rd(4'd9, d);
            check($sformatf("R7 table vector %0d flags", v), d, {6'b0, VECS[v].exp_flags});
            check($sformatf("R9 table vector %0d pin high, enables off", v), {7'b0, int_n}, 8'h01);
        end

        // R6: match present but no tick
        for (int k = 0; k < 4; k++) wr(4'(k), 8'h80);
        for (int k = 5; k < 8; k++) wr(4'(k), 8'h80);
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        wr(4'd9, 8'h00);
        repeat (5) @(negedge clk);
        rd(4'd9, d); check("R6 no tick no flag", d, 8'h00);

        // R9: enable alarm 1, interrupt level
        set_time(8'h07, 8'h00, 8'h00, 8'h01, 8'h01);
        wr(4'd8, 8'h05);
        tick_once();
        #1 check("R9 irq asserted", {7'b0, int_n}, 8'h00);
        repeat (4) @(negedge clk);
        #1 check("R9 irq held", {7'b0, int_n}, 8'h00);
        // R8: write one keeps
        wr(4'd9, 8'h01);
        rd(4'd9, d); check("R8 write one keeps", d, 8'h01);
        #1 check("R9 still asserted after keep", {7'b0, int_n}, 8'h00);
        wr(4'd9, 8'h00);
        #1 check("R9 released after clear", {7'b0, int_n}, 8'h01);
        rd(4'd9, d); check("R8 write zero clears", d, 8'h00);

        // R8: clear and match in same cycle -> set
        @(negedge clk);
        sec_tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd9; reg_wdata = 8'h00;
        @(negedge clk);
        sec_tick = 1'b0; reg_we = 1'b0;
        rd(4'd9, d); check("R8 match beats clear", d, 8'h01);

        // R9: alarm 2 path only
        wr(4'd9, 8'h00);
        wr(4'd8, 8'h06);
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        wr(4'd0, 8'h30);
        tick_once();
        rd(4'd9, d); check("R5 alarm2 alone at sec 00", d, 8'h02);
        #1 check("R9 irq from alarm2", {7'b0, int_n}, 8'h00);
        wr(4'd8, 8'h05);
        #1 check("R9 released when enable2 off", {7'b0, int_n}, 8'h01);

        // R10: square mode follows phase despite flags
        wr(4'd9, 8'h00);
        wr(4'd0, 8'h80);
        wr(4'd8, 8'h03);
        tick_once();
        @(negedge clk); half_phase = 1'b1;
        #1 check("R10 square high", {7'b0, int_n}, 8'h01);
        @(negedge clk); half_phase = 1'b0;
        #1 check("R10 square low", {7'b0, int_n}, 8'h00);
        rd(4'd9, d); check("R7 flag set in square mode", d, 8'h03);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule